// File: doc/BRIEF.md
# Two-level address translator

This block turns 32-bit device virtual addresses into physical addresses. It uses a two-level page table in memory. The top ten bits of the virtual address select a slot in the first-level table. The next ten bits select a slot in the second-level table. The low twelve bits are the byte offset within a 4 KiB page and pass through unchanged. Every table entry is a bare 32-bit frame number. The address of the next table, or of the final page, is that frame number shifted left by twelve. Slots with no mapping point at placeholder tables and pages, so a walk always ends with an address and never faults.

Results are held in an eight-entry fully associative translation cache. Entries are replaced in round-robin order. A hit answers one cycle after the request is accepted. A miss starts a walker. The walker makes one memory read per level, with at most one read outstanding, then installs the result in the cache and answers. Software uses a small register port to set the first-level table base, to keep a configuration word, and to flush the cache. Writing all ones to the flush register empties the cache at once. A flush that lands during a walk throws away the walk's result, and the walk starts again from the first level.

Top module: `iommu_xlate`

## Requirements
- R1: After reset, req_ready_o is 1, and busy_o, rsp_valid_o, mem_req_valid_o and reg_rvalid_o are 0. The base register (offset 0x4) and the info register (offset 0x8) both read 0.
- R2: The translated address is {second-level entry, vaddr[11:0]}, 44 bits wide.
- R3: The first-level read address is {5'b0, base, vaddr[31:22], 2'b00}. The second-level read address is {first-level entry, vaddr[21:12], 2'b00}.
- R4: When a request hits the cache, rsp_valid_o is high in the cycle after acceptance and no memory read is issued.
- R5: When a request misses, exactly two memory reads are issued, first-level then second-level. rsp_valid_o pulses in the cycle after the second-level data is returned. A later request to the same page hits.
- R6: The cache holds 8 pages and replaces them in round-robin order. On a miss with a full cache, the page installed earliest is the one evicted.
- R7: A register write of 0xFFFFFFFF to offset 0x0 empties the cache, so every later request misses. A write of any other value to offset 0x0 has no effect.
- R8: A flush during a walk discards that walk. A new walk then starts from the first level, and its result is installed and returned.
- R9: Register reads return a result one cycle later on reg_rvalid_o: offset 0x4 gives the 27-bit base zero-extended, offset 0x8 gives the info word, and offset 0x0 gives 0. Every access is taken in the cycle it is presented, including a base read followed at once by a flush write.
- R10: busy_o is high and req_ready_o is low from the acceptance of a missing request until its response.
- R11: While mem_req_valid_o waits for mem_req_ready_i, it stays high and mem_addr_o stays stable. No new read is issued while the previous one has not yet returned its data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Request can be accepted |
| req_vaddr_i | input | 32 | Virtual address to translate |
| rsp_valid_o | output | 1 | One-cycle response pulse |
| rsp_paddr_o | output | 44 | Translated physical address |
| mem_req_valid_o | output | 1 | Table read request |
| mem_req_ready_i | input | 1 | Memory accepts the read |
| mem_addr_o | output | 44 | Byte address of the table entry |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Table entry (frame number) |
| reg_valid_i | input | 1 | Register access valid |
| reg_write_i | input | 1 | 1 for write, 0 for read |
| reg_addr_i | input | 4 | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rvalid_o | output | 1 | Read data valid |
| reg_rdata_o | output | 32 | Read data |
| busy_o | output | 1 | Walk in progress |

## Verification
The assertions assume the memory returns exactly one data beat for each accepted read, and never returns data without a read pending. They also assume a new request arrives only while req_ready_o is high. The bench's memory model follows these rules: it answers each accepted read once, after a random delay of zero to two cycles, or after a fixed delay in the directed flush-during-walk case. Table contents are a hash of the address mixed with a generation number. The bench changes the generation only together with a flush, so a stale cached translation would show up as a wrong address.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int unsigned PG_OFF_W = 12;
  localparam int unsigned IDX_W    = 10;
  localparam logic [3:0]  OFF_FLUSH = 4'h0;
  localparam logic [3:0]  OFF_BASE  = 4'h4;
  localparam logic [3:0]  OFF_INFO  = 4'h8;

  typedef enum logic [2:0] {
    W_IDLE, W_L1_REQ, W_L1_WAIT, W_L2_REQ, W_L2_WAIT
  } walk_st_e;
endpackage

// File: rtl/xlate_regs.sv
module xlate_regs import xlate_pkg::*; #(
  parameter int unsigned BASE_W = 27,
  parameter int unsigned DW     = 32,
  parameter int unsigned AW     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_valid_i,
  input  logic              reg_write_i,
  input  logic [AW-1:0]     reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic              reg_rvalid_o,
  output logic [DW-1:0]     reg_rdata_o,
  output logic [BASE_W-1:0] base_o,
  output logic              flush_o
);
  logic [BASE_W-1:0] base_q;
  logic [DW-1:0]     info_q;
  logic              wr, rd;

  assign wr      = reg_valid_i && reg_write_i;
  assign rd      = reg_valid_i && !reg_write_i;
  assign flush_o = wr && (reg_addr_i == AW'(OFF_FLUSH)) && (reg_wdata_i == '1);
  assign base_o  = base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q       <= '0;
      info_q       <= '0;
      reg_rvalid_o <= 1'b0;
      reg_rdata_o  <= '0;
    end else begin
      if (wr && reg_addr_i == AW'(OFF_BASE)) base_q <= reg_wdata_i[BASE_W-1:0];
      if (wr && reg_addr_i == AW'(OFF_INFO)) info_q <= reg_wdata_i;
      reg_rvalid_o <= rd;
      if (rd) begin
        unique case (reg_addr_i)
          AW'(OFF_BASE): reg_rdata_o <= {{(DW-BASE_W){1'b0}}, base_q};
          AW'(OFF_INFO): reg_rdata_o <= info_q;
          default:       reg_rdata_o <= '0;
        endcase
      end
    end
  end

  AST_READ_ANSWERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_valid_i && !reg_write_i) |=> reg_rvalid_o); // R9
endmodule

// File: rtl/xlate_tlb.sv
module xlate_tlb #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned VPN_W = 20,
  parameter int unsigned PFN_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VPN_W-1:0] lookup_vpn_i,
  output logic             hit_o,
  output logic [PFN_W-1:0] hit_pfn_o,
  input  logic             fill_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PFN_W-1:0] fill_pfn_i,
  input  logic             flush_i
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] vld_q, match;
  logic [VPN_W-1:0] tag_q [DEPTH];
  logic [PFN_W-1:0] pfn_q [DEPTH];
  logic [PTR_W-1:0] ptr_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    assign match[g] = vld_q[g] && (tag_q[g] == lookup_vpn_i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tag_q[g] <= '0;
        pfn_q[g] <= '0;
      end else if (fill_i && ptr_q == PTR_W'(g)) begin
        tag_q[g] <= fill_vpn_i;
        pfn_q[g] <= fill_pfn_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else begin
      if (flush_i)     vld_q <= '0;
      else if (fill_i) vld_q[ptr_q] <= 1'b1;
      if (fill_i) ptr_q <= (ptr_q == PTR_W'(DEPTH-1)) ? '0 : ptr_q + 1'b1;
    end
  end

  assign hit_o = |match;
  always_comb begin
    hit_pfn_o = '0;
    for (int i = 0; i < DEPTH; i++)
      if (match[i]) hit_pfn_o = hit_pfn_o | pfn_q[i];
  end

  AST_TAG_UNIQUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match)); // R6
  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !hit_o); // R7
endmodule

// File: rtl/xlate_walker.sv
module xlate_walker import xlate_pkg::*; #(
  parameter int unsigned VA_W    = 32,
  parameter int unsigned ENTRY_W = 32,
  parameter int unsigned BASE_W  = 27
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic [VA_W-1:0]             vaddr_i,
  input  logic [BASE_W-1:0]           base_i,
  input  logic                        flush_i,
  output logic                        mem_req_valid_o,
  input  logic                        mem_req_ready_i,
  output logic [ENTRY_W+PG_OFF_W-1:0] mem_addr_o,
  input  logic                        mem_rsp_valid_i,
  input  logic [ENTRY_W-1:0]          mem_rsp_data_i,
  output logic                        busy_o,
  output logic                        done_o,
  output logic [ENTRY_W-1:0]          done_pfn_o,
  output logic [VA_W-1:0]             va_o
);
  localparam int unsigned PA_W  = ENTRY_W + PG_OFF_W;
  localparam int unsigned PAD_W = PA_W - BASE_W - IDX_W - 2;

  walk_st_e           st_q;
  logic [VA_W-1:0]    va_q;
  logic [BASE_W-1:0]  base_q;
  logic [ENTRY_W-1:0] l1_q;
  logic               abort_q;
  logic [PA_W-1:0]    l1_addr, l2_addr;

  assign l1_addr = {{PAD_W{1'b0}}, base_q, va_q[VA_W-1 -: IDX_W], 2'b00};
  assign l2_addr = {l1_q, va_q[PG_OFF_W +: IDX_W], 2'b00};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= W_IDLE;
      va_q    <= '0;
      base_q  <= '0;
      l1_q    <= '0;
      abort_q <= 1'b0;
    end else begin
      unique case (st_q)
        W_IDLE: if (start_i) begin
          va_q    <= vaddr_i;
          base_q  <= base_i;
          abort_q <= 1'b0;
          st_q    <= W_L1_REQ;
        end
        W_L1_REQ: if (mem_req_ready_i) begin
          abort_q <= flush_i;
          st_q    <= W_L1_WAIT;
        end
        W_L1_WAIT: begin
          if (mem_rsp_valid_i) begin
            if (abort_q || flush_i) begin
              abort_q <= 1'b0;
              base_q  <= base_i;
              st_q    <= W_L1_REQ;
            end else begin
              l1_q <= mem_rsp_data_i;
              st_q <= W_L2_REQ;
            end
          end else begin
            abort_q <= abort_q || flush_i;
          end
        end
        W_L2_REQ: begin
          abort_q <= abort_q || flush_i;
          if (mem_req_ready_i) st_q <= W_L2_WAIT;
        end
        W_L2_WAIT: begin
          if (mem_rsp_valid_i) begin
            abort_q <= 1'b0;
            if (abort_q || flush_i) begin
              base_q <= base_i;
              st_q   <= W_L1_REQ;
            end else begin
              st_q <= W_IDLE;
            end
          end else begin
            abort_q <= abort_q || flush_i;
          end
        end
        default: st_q <= W_IDLE;
      endcase
    end
  end

  assign mem_req_valid_o = (st_q == W_L1_REQ) || (st_q == W_L2_REQ);
  assign mem_addr_o      = (st_q == W_L2_REQ) ? l2_addr : l1_addr;
  assign busy_o          = (st_q != W_IDLE);
  assign done_o          = (st_q == W_L2_WAIT) && mem_rsp_valid_i && !abort_q && !flush_i;
  assign done_pfn_o      = mem_rsp_data_i;
  assign va_o            = va_q;

  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_addr_o))); // R11
  AST_ONE_OUTSTANDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && mem_req_ready_i) |=> !mem_req_valid_o); // R11
  AST_FLUSH_RESTARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && flush_i) |=> busy_o); // R8
endmodule

// File: rtl/iommu_xlate.sv
module iommu_xlate import xlate_pkg::*; #(
  parameter int unsigned VA_W      = 32,
  parameter int unsigned ENTRY_W   = 32,
  parameter int unsigned BASE_W    = 27,
  parameter int unsigned TLB_DEPTH = 8,
  parameter int unsigned REG_AW    = 4,
  parameter int unsigned REG_DW    = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_valid_i,
  output logic                        req_ready_o,
  input  logic [VA_W-1:0]             req_vaddr_i,
  output logic                        rsp_valid_o,
  output logic [ENTRY_W+PG_OFF_W-1:0] rsp_paddr_o,
  output logic                        mem_req_valid_o,
  input  logic                        mem_req_ready_i,
  output logic [ENTRY_W+PG_OFF_W-1:0] mem_addr_o,
  input  logic                        mem_rsp_valid_i,
  input  logic [ENTRY_W-1:0]          mem_rsp_data_i,
  input  logic                        reg_valid_i,
  input  logic                        reg_write_i,
  input  logic [REG_AW-1:0]           reg_addr_i,
  input  logic [REG_DW-1:0]           reg_wdata_i,
  output logic                        reg_rvalid_o,
  output logic [REG_DW-1:0]           reg_rdata_o,
  output logic                        busy_o
);
  localparam int unsigned VPN_W = VA_W - PG_OFF_W;

  logic               busy, fire, tlb_hit, flush, done;
  logic [ENTRY_W-1:0] hit_pfn, done_pfn;
  logic [VA_W-1:0]    walk_va;
  logic [BASE_W-1:0]  base;

  assign req_ready_o = !busy;
  assign fire        = req_valid_i && req_ready_o;
  assign busy_o      = busy;

  xlate_regs #(.BASE_W(BASE_W), .DW(REG_DW), .AW(REG_AW)) u_regs (
    .clk_i, .rst_ni, .reg_valid_i, .reg_write_i, .reg_addr_i, .reg_wdata_i,
    .reg_rvalid_o, .reg_rdata_o, .base_o(base), .flush_o(flush)
  );

  xlate_tlb #(.DEPTH(TLB_DEPTH), .VPN_W(VPN_W), .PFN_W(ENTRY_W)) u_tlb (
    .clk_i, .rst_ni,
    .lookup_vpn_i(req_vaddr_i[VA_W-1:PG_OFF_W]),
    .hit_o(tlb_hit), .hit_pfn_o(hit_pfn),
    .fill_i(done), .fill_vpn_i(walk_va[VA_W-1:PG_OFF_W]), .fill_pfn_i(done_pfn),
    .flush_i(flush)
  );

  xlate_walker #(.VA_W(VA_W), .ENTRY_W(ENTRY_W), .BASE_W(BASE_W)) u_walk (
    .clk_i, .rst_ni,
    .start_i(fire && !tlb_hit), .vaddr_i(req_vaddr_i), .base_i(base), .flush_i(flush),
    .mem_req_valid_o, .mem_req_ready_i, .mem_addr_o, .mem_rsp_valid_i, .mem_rsp_data_i,
    .busy_o(busy), .done_o(done), .done_pfn_o(done_pfn), .va_o(walk_va)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_paddr_o <= '0;
    end else begin
      rsp_valid_o <= (fire && tlb_hit) || done;
      if (done)                rsp_paddr_o <= {done_pfn, walk_va[PG_OFF_W-1:0]};
      else if (fire && tlb_hit) rsp_paddr_o <= {hit_pfn, req_vaddr_i[PG_OFF_W-1:0]};
    end
  end

  AST_HIT_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && tlb_hit) |=> (rsp_valid_o && !busy_o)); // R4
  AST_MISS_WALKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !tlb_hit) |=> (busy_o && !rsp_valid_o)); // R5
  AST_BUSY_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !req_ready_o); // R10
endmodule

// File: tb/iommu_xlate_tb_top.sv
module iommu_xlate_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TLB_N = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid_i = 1'b0, req_ready_o;
  logic [31:0] req_vaddr_i = '0;
  logic rsp_valid_o;
  logic [43:0] rsp_paddr_o;
  logic mem_req_valid_o, mem_req_ready_i, mem_rsp_valid_i;
  logic [43:0] mem_addr_o;
  logic [31:0] mem_rsp_data_i;
  logic reg_valid_i = 1'b0, reg_write_i = 1'b0, reg_rvalid_o, busy_o;
  logic [3:0] reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0, reg_rdata_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  iommu_xlate dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i, .req_ready_o, .req_vaddr_i, .rsp_valid_o, .rsp_paddr_o,
    .mem_req_valid_o, .mem_req_ready_i, .mem_addr_o, .mem_rsp_valid_i, .mem_rsp_data_i,
    .reg_valid_i, .reg_write_i, .reg_addr_i, .reg_wdata_i, .reg_rvalid_o, .reg_rdata_o,
    .busy_o
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_err = 0;
  int gen = 0, fixed_lat = -1, last_data_cyc = 0;
  logic [26:0] base_val = '0;
  logic [43:0] rd_log[$];

  logic [19:0] rt_vpn[TLB_N];
  logic [31:0] rt_pfn[TLB_N];
  bit          rt_v[TLB_N];
  int          rt_ptr = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mf(input logic [43:0] a);
    logic [31:0] x;
    x = (a[31:0] ^ {20'h0, a[43:32]}) * 32'h9E3779B1;
    return x ^ (gen * 32'h01000193) ^ 32'h5A5A0000;
  endfunction

  function automatic logic [43:0] l1a(input logic [31:0] va);
    return {5'b0, base_val, va[31:22], 2'b00};
  endfunction
  function automatic logic [43:0] l2a(input logic [31:0] va);
    return {mf(l1a(va)), va[21:12], 2'b00};
  endfunction
  function automatic logic [43:0] exp_pa(input logic [31:0] va);
    return {mf(l2a(va)), va[11:0]};
  endfunction

  function automatic bit rt_lookup(input logic [19:0] vpn, output logic [31:0] pfn);
    pfn = '0;
    for (int i = 0; i < TLB_N; i++)
      if (rt_v[i] && rt_vpn[i] == vpn) begin pfn = rt_pfn[i]; return 1'b1; end
    return 1'b0;
  endfunction
  task automatic rt_fill(input logic [19:0] vpn, input logic [31:0] pfn);
    rt_vpn[rt_ptr] = vpn; rt_pfn[rt_ptr] = pfn; rt_v[rt_ptr] = 1'b1;
    rt_ptr = (rt_ptr + 1) % TLB_N;
  endtask
  task automatic rt_flush();
    for (int i = 0; i < TLB_N; i++) rt_v[i] = 1'b0;
  endtask

  // memory model: answers each accepted read once after a delay
  initial begin
    bit pend = 0;
    int cnt = 0;
    logic [31:0] dat = '0;
    mem_req_ready_i = 1'b0; mem_rsp_valid_i = 1'b0; mem_rsp_data_i = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid_i = 1'b0;
      if (pend) begin
        mem_req_ready_i = 1'b0;
        if (cnt == 0) begin
          mem_rsp_valid_i = 1'b1; mem_rsp_data_i = dat; pend = 0; last_data_cyc = cyc;
        end else cnt--;
      end else begin
        mem_req_ready_i = ($urandom % 4) != 0;
        if (rst_n && mem_req_valid_o && mem_req_ready_i) begin
          rd_log.push_back(mem_addr_o);
          dat = mf(mem_addr_o);
          pend = 1;
          cnt = (fixed_lat >= 0) ? fixed_lat : int'($urandom % 3);
        end
      end
    end
  end

  task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_valid_i = 1'b1; reg_write_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_valid_i = 1'b0; reg_write_i = 1'b0;
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [31:0] d, output bit ok);
    @(negedge clk);
    reg_valid_i = 1'b1; reg_write_i = 1'b0; reg_addr_i = a;
    @(negedge clk);
    reg_valid_i = 1'b0;
    ok = reg_rvalid_o; d = reg_rdata_o;
  endtask

  task automatic flush_all();
    gen++;
    reg_wr(4'h0, 32'hFFFF_FFFF);
    rt_flush();
  endtask

  task automatic do_xlate(input logic [31:0] va, output bit was_hit);
    int t, acc;
    bit exp_hit;
    logic [31:0] pfn;
    logic [43:0] exp;
    exp_hit = rt_lookup(va[31:12], pfn);
    exp = exp_hit ? {pfn, va[11:0]} : exp_pa(va);
    rd_log.delete();
    @(negedge clk);
    req_valid_i = 1'b1; req_vaddr_i = va;
    t = 0;
    while (!req_ready_o && t < 200) begin @(negedge clk); t++; end
    acc = cyc;
    @(negedge clk);
    req_valid_i = 1'b0;
    if (!exp_hit) chk(busy_o && !req_ready_o, "R10 busy during walk", {busy_o, req_ready_o}, 2'b10);
    t = 0;
    while (!rsp_valid_o && t < 500) begin @(negedge clk); t++; end
    was_hit = (rd_log.size() == 0);
    chk(rsp_valid_o, "R5 response seen", rsp_valid_o, 1);
    chk(rsp_paddr_o == exp, "R2 physical address", rsp_paddr_o, exp);
    chk(was_hit == exp_hit, "R6 hit or miss", was_hit, exp_hit);
    if (exp_hit) chk(cyc == acc + 1, "R4 hit latency", cyc, acc + 1);
    else begin
      chk(rd_log.size() == 2, "R5 read count", rd_log.size(), 2);
      if (rd_log.size() == 2) begin
        chk(rd_log[0] == l1a(va), "R3 first-level address", rd_log[0], l1a(va));
        chk(rd_log[1] == l2a(va), "R3 second-level address", rd_log[1], l2a(va));
      end
      chk(cyc == last_data_cyc + 1, "R5 response timing", cyc, last_data_cyc + 1);
      rt_fill(va[19+12:12], exp[43:12]);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    bit ok, h;
    void'($urandom(32'd20240611));
    for (int i = 0; i < TLB_N; i++) rt_v[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready_o && !busy_o && !rsp_valid_o && !mem_req_valid_o && !reg_rvalid_o,
        "R1 reset outputs", {req_ready_o, busy_o, rsp_valid_o, mem_req_valid_o, reg_rvalid_o}, 5'b10000);
    reg_rd(4'h4, d, ok); chk(ok && d == 0, "R1 base after reset", d, 0);
    reg_rd(4'h8, d, ok); chk(ok && d == 0, "R1 info after reset", d, 0);

    // R9 register reads
    reg_wr(4'h4, 32'hFFFF_FFFF); base_val = 27'h7FF_FFFF;
    reg_rd(4'h4, d, ok); chk(ok && d == 32'h07FF_FFFF, "R9 base width", d, 32'h07FF_FFFF);
    reg_wr(4'h8, 32'hC0DE_1234);
    reg_rd(4'h8, d, ok); chk(ok && d == 32'hC0DE_1234, "R9 info word", d, 32'hC0DE_1234);
    reg_rd(4'h0, d, ok); chk(ok && d == 0, "R9 flush reads zero", d, 0);
    base_val = 27'h012_3456;
    reg_wr(4'h4, {5'b0, base_val});

    // R5 miss then hit, R2 passthrough offset
    do_xlate(32'h0040_1ABC, h); chk(!h, "R5 first access misses", h, 0);
    do_xlate(32'h0040_1FFF, h); chk(h, "R5 same page hits", h, 1);

    // R7 non-all-ones write to flush offset ignored
    reg_wr(4'h0, 32'h1234_5678);
    do_xlate(32'h0040_1000, h); chk(h, "R7 partial write keeps entry", h, 1);
    // R9 read base then flush back to back
    @(negedge clk);
    reg_valid_i = 1'b1; reg_write_i = 1'b0; reg_addr_i = 4'h4;
    @(negedge clk);
    gen++;
    reg_write_i = 1'b1; reg_addr_i = 4'h0; reg_wdata_i = 32'hFFFF_FFFF;
    chk(reg_rvalid_o && reg_rdata_o == {5'b0, base_val}, "R9 read before flush", reg_rdata_o, {5'b0, base_val});
    @(negedge clk);
    reg_valid_i = 1'b0; reg_write_i = 1'b0;
    rt_flush();
    do_xlate(32'h0040_1000, h); chk(!h, "R7 flush empties cache", h, 0);

    // R6 capacity and round-robin eviction
    flush_all();
    for (int i = 0; i < TLB_N; i++) begin do_xlate({10'(i), 10'(3*i+1), 12'h010}, h); end
    for (int i = 0; i < TLB_N; i++) begin
      do_xlate({10'(i), 10'(3*i+1), 12'h020}, h); chk(h, "R6 eight pages held", h, 1);
    end
    do_xlate({10'h3FF, 10'h3FF, 12'h0}, h); chk(!h, "R6 ninth page misses", h, 0);
    do_xlate({10'd0, 10'd1, 12'h0}, h); chk(!h, "R6 oldest evicted", h, 0);
    do_xlate({10'd2, 10'd7, 12'h0}, h); chk(h, "R6 others kept", h, 1);

    // R8 flush during a walk
    flush_all();
    fixed_lat = 6;
    rd_log.delete();
    fork
      begin
        int t;
        @(negedge clk);
        req_valid_i = 1'b1; req_vaddr_i = 32'h8020_3456;
        while (!req_ready_o) @(negedge clk);
        @(negedge clk);
        req_valid_i = 1'b0;
        t = 0;
        while (!rsp_valid_o && t < 500) begin @(negedge clk); t++; end
      end
      begin
        while (rd_log.size() < 1) @(negedge clk);
        @(negedge clk);
        gen++;
        reg_valid_i = 1'b1; reg_write_i = 1'b1; reg_addr_i = 4'h0; reg_wdata_i = 32'hFFFF_FFFF;
        @(negedge clk);
        reg_valid_i = 1'b0; reg_write_i = 1'b0;
        rt_flush();
      end
    join
    chk(rsp_paddr_o == exp_pa(32'h8020_3456), "R8 restarted result", rsp_paddr_o, exp_pa(32'h8020_3456));
    chk(rd_log.size() == 3, "R8 walk restarted", rd_log.size(), 3);
    if (rd_log.size() == 3)
      chk(rd_log[1] == l1a(32'h8020_3456), "R8 restart from first level", rd_log[1], l1a(32'h8020_3456));
    rt_fill(20'h80203, exp_pa(32'h8020_3456) >> 12);
    fixed_lat = -1;
    do_xlate(32'h8020_3000, h); chk(h, "R8 restarted walk installed", h, 1);

    // random traffic over a 12-page pool
    for (int n = 0; n < 300; n++) begin
      logic [9:0] l1s[3];
      logic [9:0] l2s[4];
      l1s = '{10'h000, 10'h001, 10'h3FF};
      l2s = '{10'h000, 10'h001, 10'h155, 10'h3FF};
      if (($urandom % 40) == 0) flush_all();
      do_xlate({l1s[$urandom % 3], l2s[$urandom % 4], 12'($urandom)}, h);
    end
    finish_run();
  end
endmodule